// File: doc/BRIEF.md
# Level-Masked Interrupt Arbiter

This block decides, once per clock, whether the processor should take an external interrupt now and, if so, which one. Four request lines come in: device, timer, interprocessor and machine check. Each one is eligible only while the current interrupt priority level is at or below a fixed threshold for that source. The thresholds step up from one source to the next, so raising the level cuts off sources from the bottom up. While the core runs in privileged mode, no interrupt is taken at all.

Of the eligible requests, the most urgent one wins. The arbiter then raises a one-cycle take strobe, presents the matching cause code to the exception entry logic, and pulses an error-clear strobe so that the entry logic zeroes its error code. Requests are levels that belong to their sources. The arbiter never clears them. After a take it holds off for one cycle, so that the entry logic can switch into privileged mode before the same level is seen again.

Top module: `irq_lvl_arb`

## Requirements
- R1: While reset is active and on the first cycle after it, `take` and `err_clear` are 0 and `cause` is 0 (none).
- R2: While `priv_mode` is 1, no interrupt is taken, whatever the requests and level are.
- R3: At levels 0 to 3, every source is eligible. A lone device request at level 3 is taken with cause 1.
- R4: At level 4, device requests are ignored and timer, interprocessor and machine check are eligible. At level 5, only interprocessor and machine check are eligible. At level 6, only machine check is eligible.
- R5: At level 7, no request is taken.
- R6: Among eligible requests, machine check (cause 4) beats interprocessor (cause 3). Interprocessor beats timer (cause 2), and timer beats device (cause 1).
- R7: `take` is high for one cycle only. In the cycle after a take it is low even if the request is still held, and a held request is taken again one cycle later.
- R8: `cause` is registered together with `take`, one clock after the inputs that select it. It holds its value on every cycle without a take.
- R9: `err_clear` is high in exactly the cycles where `take` is high, and tells the entry logic to set the error code to zero.
- R10: Requests are level-sensitive and never latched. A request that drops before it is eligible is never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | 1 | Device interrupt request level |
| tmr_req | input | 1 | Timer interrupt request level |
| ipi_req | input | 1 | Interprocessor interrupt request level |
| mchk_req | input | 1 | Machine-check request level |
| cur_ipl | input | IPL_W (3) | Current interrupt priority level |
| priv_mode | input | 1 | Privileged mode active; blocks all takes |
| take | output | 1 | One-cycle strobe: an interrupt is taken |
| cause | output | 3 | Cause code of the last take (0 none, 1 device, 2 timer, 3 interprocessor, 4 machine check) |
| err_clear | output | 1 | Strobe to zero the error code, with `take` |

## Verification
The bench builds the arbiter with its default parameters: a 3-bit level and thresholds of 3, 4, 5 and 6 for device, timer, interprocessor and machine check. This covers all eight levels. That includes level 7, where every source is masked, and each boundary where one more source drops out. A held request can then be checked to be retaken every other cycle, and each pair of sources can be made to contend.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

    localparam int NSRC    = 4;
    localparam int CAUSE_W = 3;

    // source slots, ordered by rising urgency
    localparam int SRC_DEV  = 0;
    localparam int SRC_TMR  = 1;
    localparam int SRC_IPI  = 2;
    localparam int SRC_MCHK = 3;
    localparam int IDX_W    = $clog2(NSRC);

    typedef enum logic [CAUSE_W-1:0] {
        CZ_NONE = 3'd0,
        CZ_DEV  = 3'd1,
        CZ_TMR  = 3'd2,
        CZ_IPI  = 3'd3,
        CZ_MCHK = 3'd4
    } cause_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic cause_e idx_to_cause(input logic [IDX_W-1:0] idx);
        cause_e c;
        case (idx)
            2'd0:    c = CZ_DEV;
            2'd1:    c = CZ_TMR;
            2'd2:    c = CZ_IPI;
            default: c = CZ_MCHK;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/irq_lvl_mask.sv
module irq_lvl_mask
    import irq_lvl_pkg::*;
#(
    parameter int IPL_W = 3,
    parameter logic [NSRC*IPL_W-1:0] LIMITS = '0
) (
    input  logic [NSRC-1:0]  req,
    input  logic [IPL_W-1:0] ipl,
    input  logic             priv_mode,
    output logic [NSRC-1:0]  elig
);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam logic [IPL_W-1:0] LIM = LIMITS[s*IPL_W +: IPL_W];
        always_comb elig[s] = req[s] && !priv_mode && (ipl <= LIM);
    end

endmodule

// File: rtl/irq_lvl_pick.sv
module irq_lvl_pick
    import irq_lvl_pkg::*;
(
    input  logic [NSRC-1:0] elig,
    output pick_t           pick
);

    always_comb begin
        pick = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (elig[s]) begin
                pick.valid = 1'b1;
                pick.idx   = IDX_W'(s);
            end
        end
    end

endmodule

// File: rtl/irq_lvl_arb.sv
module irq_lvl_arb
    import irq_lvl_pkg::*;
#(
    parameter int IPL_W    = 3,
    parameter int DEV_MAX  = 3,
    parameter int TMR_MAX  = 4,
    parameter int IPI_MAX  = 5,
    parameter int MCHK_MAX = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dev_req,
    input  logic             tmr_req,
    input  logic             ipi_req,
    input  logic             mchk_req,
    input  logic [IPL_W-1:0] cur_ipl,
    input  logic             priv_mode,
    output logic             take,
    output logic [2:0]       cause,
    output logic             err_clear
);

    localparam logic [NSRC*IPL_W-1:0] LIMITS = {
        IPL_W'(MCHK_MAX), IPL_W'(IPI_MAX), IPL_W'(TMR_MAX), IPL_W'(DEV_MAX)
    };

    logic [NSRC-1:0] req_vec;
    logic [NSRC-1:0] elig;
    pick_t           pick;
    logic            take_q;
    logic            err_q;
    cause_e          cause_q;
    logic            fire;

    always_comb begin
        req_vec           = '0;
        req_vec[SRC_DEV]  = dev_req;
        req_vec[SRC_TMR]  = tmr_req;
        req_vec[SRC_IPI]  = ipi_req;
        req_vec[SRC_MCHK] = mchk_req;
    end

    irq_lvl_mask #(
        .IPL_W  (IPL_W),
        .LIMITS (LIMITS)
    ) u_mask (
        .req       (req_vec),
        .ipl       (cur_ipl),
        .priv_mode (priv_mode),
        .elig      (elig)
    );

    irq_lvl_pick u_pick (
        .elig (elig),
        .pick (pick)
    );

    // one-cycle hold-off after each take
    always_comb fire = pick.valid && !take_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q  <= 1'b0;
            err_q   <= 1'b0;
            cause_q <= CZ_NONE;
        end else begin
            take_q <= fire;
            err_q  <= fire;
            if (fire) begin
                cause_q <= idx_to_cause(pick.idx);
            end
        end
    end

    assign take      = take_q;
    assign err_clear = err_q;
    assign cause     = cause_q;

endmodule

// File: rtl/irq_lvl_arb_chk.sv
module irq_lvl_arb_chk #(
    parameter int IPL_W    = 3,
    parameter int DEV_MAX  = 3,
    parameter int MCHK_MAX = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [IPL_W-1:0] cur_ipl,
    input logic             priv_mode,
    input logic             take,
    input logic [2:0]       cause,
    input logic             err_clear
);

    assert_no_back_to_back_R7: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    assert_priv_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(!priv_mode));

    assert_top_level_masked_R5: assert property (@(posedge clk) disable iff (rst)
        take |-> ($past(cur_ipl) <= IPL_W'(MCHK_MAX)));

    assert_dev_threshold_R4: assert property (@(posedge clk) disable iff (rst)
        (take && cause == 3'd1) |-> ($past(cur_ipl) <= IPL_W'(DEV_MAX)));

    assert_cause_holds_R8: assert property (@(posedge clk) disable iff (rst)
        !take |-> $stable(cause));

    assert_cause_known_R6: assert property (@(posedge clk) disable iff (rst)
        take |-> (cause >= 3'd1 && cause <= 3'd4));

    assert_err_with_take_R9: assert property (@(posedge clk) disable iff (rst)
        err_clear == take);

endmodule

bind irq_lvl_arb irq_lvl_arb_chk #(
    .IPL_W    (IPL_W),
    .DEV_MAX  (DEV_MAX),
    .MCHK_MAX (MCHK_MAX)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cur_ipl   (cur_ipl),
    .priv_mode (priv_mode),
    .take      (take),
    .cause     (cause),
    .err_clear (err_clear)
);

// File: tb/sim_irq_lvl_arb.sv
`timescale 1ns/1ps
module sim_irq_lvl_arb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dev_req = 1'b0, tmr_req = 1'b0, ipi_req = 1'b0, mchk_req = 1'b0;
    logic [2:0] cur_ipl = 3'd0;
    logic       priv_mode = 1'b0;
    logic       take, err_clear;
    logic [2:0] cause;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic       take;
        logic [2:0] cause;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    logic       prev_take  = 1'b0;
    logic [2:0] last_cause = 3'd0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    irq_lvl_arb u0 (
        .clk(clk), .rst(rst), .dev_req(dev_req), .tmr_req(tmr_req),
        .ipi_req(ipi_req), .mchk_req(mchk_req), .cur_ipl(cur_ipl),
        .priv_mode(priv_mode), .take(take), .cause(cause), .err_clear(err_clear)
    );

    function automatic logic [2:0] model(logic d, logic t, logic i, logic m,
                                         logic [2:0] l, logic p);
        if (p)                   return 3'd0;
        if (m && l <= 3'd6)      return 3'd4;
        if (i && l <= 3'd5)      return 3'd3;
        if (t && l <= 3'd4)      return 3'd2;
        if (d && l <= 3'd3)      return 3'd1;
        return 3'd0;
    endfunction

    task automatic check(string tag, string what, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic d, logic t, logic i, logic m, logic [2:0] l,
                         logic p, string tag);
        exp_t       e;
        logic [2:0] c;
        @(negedge clk);
        dev_req = d; tmr_req = t; ipi_req = i; mchk_req = m;
        cur_ipl = l; priv_mode = p;
        c = model(d, t, i, m, l, p);
        e.take = (c != 3'd0) && !prev_take;
        if (e.take) last_cause = c;
        prev_take = e.take;
        e.cause = last_cause;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) drive(0, 0, 0, 0, 3'd0, 0, tag);
    endtask

    // monitor: compares one result per cycle against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "take", {2'b0, take}, {2'b0, e.take});
                check(e.tag, "cause", cause, e.cause);
                check("R9", "err_clear", {2'b0, err_clear}, {2'b0, e.take});
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "take", {2'b0, take}, 3'd0);
        check("R1", "cause", cause, 3'd0);
        check("R1", "err_clear", {2'b0, err_clear}, 3'd0);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R1", "take after release", {2'b0, take}, 3'd0);

        // R3: lone device at level 3
        drive(1, 0, 0, 0, 3'd3, 0, "R3");
        idle(2, "R8");
        // R7: held device request at level 0
        for (int k = 0; k < 5; k++) drive(1, 0, 0, 0, 3'd0, 0, "R7");
        idle(2, "R8");
        // R2: privileged mode blocks everything
        for (int k = 0; k < 3; k++) drive(1, 1, 1, 1, 3'd0, 1, "R2");
        idle(1, "R8");
        // R4: threshold steps
        drive(1, 0, 0, 0, 3'd4, 0, "R4"); idle(1, "R4");
        drive(0, 1, 0, 0, 3'd4, 0, "R4"); idle(1, "R4");
        drive(0, 1, 0, 0, 3'd5, 0, "R4"); idle(1, "R4");
        drive(0, 0, 1, 0, 3'd5, 0, "R4"); idle(1, "R4");
        drive(0, 0, 1, 0, 3'd6, 0, "R4"); idle(1, "R4");
        drive(0, 0, 0, 1, 3'd6, 0, "R4"); idle(1, "R4");
        // R5: level 7 masks all
        for (int k = 0; k < 3; k++) drive(1, 1, 1, 1, 3'd7, 0, "R5");
        idle(1, "R5");
        // R6: priority among contenders
        drive(1, 1, 1, 1, 3'd0, 0, "R6"); idle(1, "R6");
        drive(1, 1, 0, 0, 3'd0, 0, "R6"); idle(1, "R6");
        drive(1, 1, 1, 0, 3'd2, 0, "R6"); idle(1, "R6");
        drive(1, 0, 0, 1, 3'd1, 0, "R6"); idle(1, "R6");
        // R10: request present only while blocked, dropped before unblock
        drive(0, 1, 0, 0, 3'd0, 1, "R10");
        drive(0, 0, 0, 0, 3'd0, 0, "R10");
        drive(0, 0, 0, 0, 3'd0, 0, "R10");
        drive(0, 1, 0, 0, 3'd7, 0, "R10");
        drive(0, 0, 0, 0, 3'd0, 0, "R10");
        idle(2, "R8");
        // R8: cause holds across no-take cycles after an interprocessor take
        drive(0, 0, 1, 0, 3'd5, 0, "R8");
        idle(4, "R8");

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule